// File: doc/BRIEF.md
# Parallel Camera Capture Packer

This block sits directly behind a parallel image-sensor port. It runs in the sensor's pixel clock domain. The sensor supplies a 12-bit data bus, a frame-valid level (vertical sync), a line-valid level (horizontal sync), a field bit and an optional write-enable strobe. Static configuration inputs set the polarity of each control signal and choose which 8-bit slice of the bus carries the sample. A `PCLK_FALL` parameter selects the pixel clock edge on which the block samples.

A sample is accepted only when the corrected frame-valid and line-valid signals are both active. When the strobe qualifier is switched on, the strobe must also be high. Each pair of accepted bytes within a line is packed into one 16-bit word, and that word goes out on a single-cycle valid toward a memory writer. Every word carries the field value latched at the start of its frame, a start-of-frame flag and an end-of-line flag. A byte left without a partner when the line ends is dropped, so each new line starts on a word boundary.

Top module: `cam_pack_capture`

## Requirements
- R1: Each of vertical sync, horizontal sync and field has its own polarity bit. `cfg_vs_low`=1 or `cfg_hs_low`=1 makes that sync active-low. `cfg_fld_inv`=1 inverts the field bit before it is used.
- R2: The sample byte is chosen by `cfg_lane`: 0 selects `cam_data[7:0]`, 1 selects `cam_data[9:2]`, 2 selects `cam_data[11:4]`, and 3 falls back to `cam_data[7:0]`.
- R3: A sample is accepted only when corrected vertical and horizontal sync are both active. If `cfg_wen_use`=1, `cam_wen` must also be 1. If `cfg_wen_use`=0, `cam_wen` has no effect.
- R4: Two accepted bytes form one word, with the first byte in bits [7:0] and the second in bits [15:8]. `out_valid` is high for exactly one cycle, one clock after the edge that samples the second byte.
- R5: A pending first byte is discarded whenever corrected horizontal or vertical sync is inactive on a sampling edge.
- R6: The corrected field value is latched when corrected vertical sync becomes active. `out_field` shows that value for every word of the frame, even if the field input changes mid-frame.
- R7: `out_sof` is 1 on the first word emitted after corrected vertical sync becomes active, and 0 on every later word.
- R8: `out_eol` is 1 on a word when the sample that immediately follows its second byte has corrected horizontal sync inactive.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_sof`, `out_eol`, `out_word` and any pending byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_vsync | input | 1 | Frame-valid level from the sensor |
| cam_hsync | input | 1 | Line-valid level from the sensor |
| cam_field | input | 1 | Field indicator from the sensor |
| cam_wen | input | 1 | Optional external write strobe, active high |
| cam_data | input | IN_W (12) | Sensor data bus |
| cfg_vs_low | input | 1 | 1: vertical sync is active-low |
| cfg_hs_low | input | 1 | 1: horizontal sync is active-low |
| cfg_fld_inv | input | 1 | 1: invert the field bit |
| cfg_wen_use | input | 1 | 1: `cam_wen` qualifies samples |
| cfg_lane | input | 2 | Byte window select (see R2) |
| out_valid | output | 1 | One-cycle strobe for a packed word |
| out_word | output | 2*BYTE_W (16) | Packed word |
| out_field | output | 1 | Field of the current frame |
| out_sof | output | 1 | First word of the frame |
| out_eol | output | 1 | Word ends the line |

## Verification
The bench targets lines with an odd byte count. A design that keeps the leftover byte across the blanking gap would pair it with the first byte of the next line, and every later word on that line would be skewed by one byte. It also sends strobe gaps with the qualifier both on and off: a wrong design would either pack gap bytes or stall when the strobe should be ignored. The bench sweeps every lane code, including the reserved one, using data whose slices all differ. It flips every polarity bit and toggles the field input mid-frame, which would expose a field that is not held for the frame. It also checks that the frame and line flags land on exactly one word each.

// File: rtl/cam_pack_pkg.sv
package cam_pack_pkg;

   // Byte window codes on cfg_lane
   typedef enum logic [1:0] {
      LANE_SH0  = 2'd0,
      LANE_SH2  = 2'd1,
      LANE_SH4  = 2'd2,
      LANE_RSVD = 2'd3
   } lane_sel_e;

   // Control signals after polarity correction
   typedef struct packed {
      logic vs;
      logic hs;
      logic fld;
      logic wen_ok;
   } sync_t;

   function automatic int unsigned lane_shift(input logic [1:0] sel);
      case (lane_sel_e'(sel))
         LANE_SH2: return 2;
         LANE_SH4: return 4;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/cam_in_stage.sv
module cam_in_stage
   import cam_pack_pkg::*;
#(
   parameter int IN_W   = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cam_vsync,
   input  logic              cam_hsync,
   input  logic              cam_field,
   input  logic              cam_wen,
   input  logic [IN_W-1:0]   cam_data,
   input  logic              cfg_vs_low,
   input  logic              cfg_hs_low,
   input  logic              cfg_fld_inv,
   input  logic              cfg_wen_use,
   input  logic [1:0]        cfg_lane,
   output sync_t             st_d,
   output sync_t             st_q,
   output logic [BYTE_W-1:0] byte_q
);

   localparam int MAX_SHIFT = 4;

   if (IN_W < BYTE_W + MAX_SHIFT) begin : g_width_check
      $error("cam_in_stage: IN_W must cover BYTE_W plus the widest lane shift");
   end

   logic [BYTE_W-1:0] byte_d;

   always_comb begin
      st_d.vs     = cam_vsync ^ cfg_vs_low;
      st_d.hs     = cam_hsync ^ cfg_hs_low;
      st_d.fld    = cam_field ^ cfg_fld_inv;
      st_d.wen_ok = ~cfg_wen_use | cam_wen;
   end

   always_comb begin
      case (lane_shift(cfg_lane))
         2:       byte_d = cam_data[BYTE_W+1:2];
         4:       byte_d = cam_data[BYTE_W+3:4];
         default: byte_d = cam_data[BYTE_W-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= '0;
         byte_q <= '0;
      end else begin
         st_q   <= st_d;
         byte_q <= byte_d;
      end
   end

endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
   import cam_pack_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  sync_t               st_q,
   input  logic [BYTE_W-1:0]   byte_q,
   input  logic                hs_next,
   output logic                out_valid,
   output logic [2*BYTE_W-1:0] out_word,
   output logic                out_field,
   output logic                out_sof,
   output logic                out_eol
);

   logic              half_q;
   logic [BYTE_W-1:0] low_q;
   logic              vs_prev_q;
   logic              fld_frame_q;
   logic              sof_pend_q;

   logic accept, in_window, vs_rise, field_now, sof_now, word_done;

   always_comb begin
      in_window = st_q.vs & st_q.hs;
      accept    = in_window & st_q.wen_ok;
      vs_rise   = st_q.vs & ~vs_prev_q;
      field_now = vs_rise ? st_q.fld : fld_frame_q;
      sof_now   = vs_rise | sof_pend_q;
      word_done = accept & half_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         half_q      <= 1'b0;
         low_q       <= '0;
         vs_prev_q   <= 1'b0;
         fld_frame_q <= 1'b0;
         sof_pend_q  <= 1'b0;
         out_valid   <= 1'b0;
         out_word    <= '0;
         out_field   <= 1'b0;
         out_sof     <= 1'b0;
         out_eol     <= 1'b0;
      end else begin
         vs_prev_q <= st_q.vs;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         if (vs_rise) begin
            fld_frame_q <= st_q.fld;
         end
         if (word_done) begin
            sof_pend_q <= 1'b0;
         end else if (vs_rise) begin
            sof_pend_q <= 1'b1;
         end
         if (!in_window) begin
            half_q <= 1'b0;
         end else if (accept) begin
            if (!half_q) begin
               low_q  <= byte_q;
               half_q <= 1'b1;
            end else begin
               half_q    <= 1'b0;
               out_valid <= 1'b1;
               out_word  <= {byte_q, low_q};
               out_field <= field_now;
               out_sof   <= sof_now;
               out_eol   <= ~hs_next;
            end
         end
      end
   end

endmodule

// File: rtl/cam_pack_capture.sv
module cam_pack_capture
   import cam_pack_pkg::*;
#(
   parameter int IN_W      = 12,
   parameter int BYTE_W    = 8,
   parameter bit PCLK_FALL = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cam_vsync,
   input  logic                cam_hsync,
   input  logic                cam_field,
   input  logic                cam_wen,
   input  logic [IN_W-1:0]     cam_data,
   input  logic                cfg_vs_low,
   input  logic                cfg_hs_low,
   input  logic                cfg_fld_inv,
   input  logic                cfg_wen_use,
   input  logic [1:0]          cfg_lane,
   output logic                out_valid,
   output logic [2*BYTE_W-1:0] out_word,
   output logic                out_field,
   output logic                out_sof,
   output logic                out_eol
);

   localparam int WORD_W = 2 * BYTE_W;

   if (BYTE_W < 1) begin : g_byte_check
      $error("cam_pack_capture: BYTE_W must be positive");
   end

   logic core_clk;

   if (PCLK_FALL) begin : g_clk_fall
      assign core_clk = ~clk;
   end else begin : g_clk_rise
      assign core_clk = clk;
   end

   sync_t             st_d, st_q;
   logic [BYTE_W-1:0] byte_q;
   logic [WORD_W-1:0] word_w;

   cam_in_stage #(.IN_W(IN_W), .BYTE_W(BYTE_W)) u_in (
      .clk         (core_clk),
      .rst         (rst),
      .cam_vsync   (cam_vsync),
      .cam_hsync   (cam_hsync),
      .cam_field   (cam_field),
      .cam_wen     (cam_wen),
      .cam_data    (cam_data),
      .cfg_vs_low  (cfg_vs_low),
      .cfg_hs_low  (cfg_hs_low),
      .cfg_fld_inv (cfg_fld_inv),
      .cfg_wen_use (cfg_wen_use),
      .cfg_lane    (cfg_lane),
      .st_d        (st_d),
      .st_q        (st_q),
      .byte_q      (byte_q)
   );

   cam_word_packer #(.BYTE_W(BYTE_W)) u_pack (
      .clk       (core_clk),
      .rst       (rst),
      .st_q      (st_q),
      .byte_q    (byte_q),
      .hs_next   (st_d.hs),
      .out_valid (out_valid),
      .out_word  (word_w),
      .out_field (out_field),
      .out_sof   (out_sof),
      .out_eol   (out_eol)
   );

   assign out_word = word_w;

endmodule

// File: rtl/cam_pack_capture_chk.sv
module cam_pack_capture_chk #(
   parameter bit PCLK_FALL = 1'b0
) (
   input logic clk,
   input logic rst,
   input logic cam_vsync,
   input logic cam_hsync,
   input logic cam_wen,
   input logic cfg_vs_low,
   input logic cfg_hs_low,
   input logic cfg_wen_use,
   input logic out_valid,
   input logic out_sof,
   input logic out_eol
);

   logic chk_clk;
   assign chk_clk = PCLK_FALL ? ~clk : clk;

   logic vs_act, hs_act, wen_act;
   assign vs_act  = cam_vsync ^ cfg_vs_low;
   assign hs_act  = cam_hsync ^ cfg_hs_low;
   assign wen_act = ~cfg_wen_use | cam_wen;

   // R9: reset leaves no word strobe behind
   assert_reset_quiet_R9: assert property (@(posedge chk_clk)
      rst |=> !out_valid && !out_sof && !out_eol);

   // R4: a word strobe never lasts two cycles
   assert_valid_pulse_R4: assert property (@(posedge chk_clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R3: the byte that closes a word was sampled inside the qualified window
   assert_qualified_R3: assert property (@(posedge chk_clk) disable iff (rst)
      out_valid |-> $past(vs_act, 2) && $past(hs_act, 2) && $past(wen_act, 2));

   // R7: frame flag only rides on a word
   assert_sof_with_word_R7: assert property (@(posedge chk_clk) disable iff (rst)
      out_sof |-> out_valid);

   // R8: line flag only rides on a word, and the following sample left the line
   assert_eol_with_word_R8: assert property (@(posedge chk_clk) disable iff (rst)
      out_eol |-> out_valid && !$past(hs_act, 1));

endmodule

bind cam_pack_capture cam_pack_capture_chk #(.PCLK_FALL(PCLK_FALL)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cam_vsync   (cam_vsync),
   .cam_hsync   (cam_hsync),
   .cam_wen     (cam_wen),
   .cfg_vs_low  (cfg_vs_low),
   .cfg_hs_low  (cfg_hs_low),
   .cfg_wen_use (cfg_wen_use),
   .out_valid   (out_valid),
   .out_sof     (out_sof),
   .out_eol     (out_eol)
);

// File: tb/cam_pack_capture_test.sv
`timescale 1ns/1ps
module cam_pack_capture_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cam_vsync = 1'b0, cam_hsync = 1'b0, cam_field = 1'b0, cam_wen = 1'b0;
   logic [11:0] cam_data = '0;
   logic        cfg_vs_low = 1'b0, cfg_hs_low = 1'b0, cfg_fld_inv = 1'b0, cfg_wen_use = 1'b0;
   logic [1:0]  cfg_lane = 2'd0;
   logic        out_valid, out_field, out_sof, out_eol;
   logic [15:0] out_word;

   int n_cmp = 0;
   int n_bad = 0;

   logic [15:0] q_word[$];
   logic        q_sof[$], q_eol[$], q_fld[$];

   always #2 clk = ~clk;

   cam_pack_capture uut (
      .clk(clk), .rst(rst),
      .cam_vsync(cam_vsync), .cam_hsync(cam_hsync), .cam_field(cam_field),
      .cam_wen(cam_wen), .cam_data(cam_data),
      .cfg_vs_low(cfg_vs_low), .cfg_hs_low(cfg_hs_low), .cfg_fld_inv(cfg_fld_inv),
      .cfg_wen_use(cfg_wen_use), .cfg_lane(cfg_lane),
      .out_valid(out_valid), .out_word(out_word), .out_field(out_field),
      .out_sof(out_sof), .out_eol(out_eol)
   );

   always @(negedge clk) begin
      if (!rst && out_valid) begin
         q_word.push_back(out_word);
         q_sof.push_back(out_sof);
         q_eol.push_back(out_eol);
         q_fld.push_back(out_field);
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Drive one sample; vs/hs are given as active levels, field as the pin level
   task automatic step(input logic vs, input logic hs, input logic wen,
                       input logic fld, input logic [11:0] d);
      @(negedge clk);
      cam_vsync = vs ^ cfg_vs_low;
      cam_hsync = hs ^ cfg_hs_low;
      cam_wen   = wen;
      cam_field = fld;
      cam_data  = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
   endtask

   task automatic clear_q();
      q_word.delete(); q_sof.delete(); q_eol.delete(); q_fld.delete();
   endtask

   task automatic chk_word(input string req, input int idx, input logic [15:0] w,
                           input logic sof, input logic eol, input logic fld);
      if (idx >= q_word.size()) begin
         chk({req, " word missing"}, 32'(q_word.size()), 32'(idx + 1));
      end else begin
         chk({req, " word"}, 32'(q_word[idx]), 32'(w));
         chk({req, " sof"},  32'(q_sof[idx]),  32'(sof));
         chk({req, " eol"},  32'(q_eol[idx]),  32'(eol));
         chk({req, " field"}, 32'(q_fld[idx]), 32'(fld));
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 valid in reset", 32'(out_valid), 32'd0);
      chk("R9 word in reset",  32'(out_word),  32'd0);
      chk("R9 flags in reset", 32'({out_sof, out_eol}), 32'd0);
      rst = 1'b0;
      idle(2);
   endtask

   // R4 R6 R7 R8, wen ignored when qualifier is off (R3)
   task automatic t_basic_line();
      clear_q();
      step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
      for (int i = 0; i < 6; i++)
         step(1'b1, 1'b1, 1'b0, (i < 3) ? 1'b1 : 1'b0, {4'hA, 8'(8'h11 + i)});
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      idle(3);
      chk("R4 R3 basic count", 32'(q_word.size()), 32'd3);
      chk_word("R4 R7 R6 basic w0", 0, 16'h1211, 1'b1, 1'b0, 1'b1);
      chk_word("R4 R6 basic w1",    1, 16'h1413, 1'b0, 1'b0, 1'b1);
      chk_word("R8 R6 basic w2",    2, 16'h1615, 1'b0, 1'b1, 1'b1);
   endtask

   // R5: odd line drops its spare byte, next line realigns
   task automatic t_odd_line();
      clear_q();
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 1'b0, {4'h0, 8'(8'h21 + i)});
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0, {4'h0, 8'(8'h31 + i)});
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      idle(3);
      chk("R5 odd count", 32'(q_word.size()), 32'd4);
      chk_word("R5 R7 odd w0", 0, 16'h2221, 1'b1, 1'b0, 1'b0);
      chk_word("R5 odd w1",    1, 16'h2423, 1'b0, 1'b0, 1'b0);
      chk_word("R5 odd w2",    2, 16'h3231, 1'b0, 1'b0, 1'b0);
      chk_word("R5 R8 odd w3", 3, 16'h3433, 1'b0, 1'b1, 1'b0);
   endtask

   // R3: strobe gaps drop samples when the qualifier is on
   task automatic t_wen_gate();
      logic [5:0] pat = 6'b101101;
      cfg_wen_use = 1'b1;
      clear_q();
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, pat[i], 1'b0, {4'h0, 8'(8'h41 + i)});
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      idle(3);
      cfg_wen_use = 1'b0;
      chk("R3 wen count", 32'(q_word.size()), 32'd2);
      chk_word("R3 wen w0", 0, 16'h4341, 1'b1, 1'b0, 1'b0);
      chk_word("R3 R8 wen w1", 1, 16'h4644, 1'b0, 1'b1, 1'b0);
   endtask

   // R2: every lane code
   task automatic t_lanes();
      logic [11:0] d0 = 12'hABC;
      logic [11:0] d1 = 12'h5A3;
      for (int l = 0; l < 4; l++) begin
         int sh = (l == 1) ? 2 : (l == 2) ? 4 : 0;
         logic [15:0] e = {8'(d1 >> sh), 8'(d0 >> sh)};
         cfg_lane = 2'(l);
         clear_q();
         step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
         step(1'b1, 1'b1, 1'b0, 1'b0, d0);
         step(1'b1, 1'b1, 1'b0, 1'b0, d1);
         step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
         idle(3);
         chk("R2 lane count", 32'(q_word.size()), 32'd1);
         chk_word($sformatf("R2 lane %0d", l), 0, e, 1'b1, 1'b1, 1'b0);
      end
      cfg_lane = 2'd0;
   endtask

   // R1: all polarities flipped
   task automatic t_polarity();
      cfg_vs_low = 1'b1; cfg_hs_low = 1'b1; cfg_fld_inv = 1'b1;
      idle(3);
      clear_q();
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      step(1'b1, 1'b1, 1'b0, 1'b0, 12'h061);
      step(1'b1, 1'b1, 1'b0, 1'b1, 12'h062);
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      idle(3);
      chk("R1 inverted count", 32'(q_word.size()), 32'd1);
      chk_word("R1 inverted w0", 0, 16'h6261, 1'b1, 1'b1, 1'b1);
      cfg_vs_low = 1'b0; cfg_hs_low = 1'b0; cfg_fld_inv = 1'b0;
      idle(3);
   endtask

   // R3: one sync alone opens nothing
   task automatic t_sync_gate();
      clear_q();
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 12'h071);
      idle(1);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 12'h072);
      idle(3);
      chk("R3 one sync only count", 32'(q_word.size()), 32'd0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_basic_line();
            t_odd_line();
            t_wen_gate();
            t_lanes();
            t_polarity();
            t_sync_gate();
         end
         begin
            repeat (100000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule